// File: doc/BRIEF.md
# Two-Wire Target With Auto-Incrementing Register Window

This block is a two-wire serial target that answers at one fixed 7-bit device address. It exposes a 256-byte register window to a bus controller. A transaction addressed for writing takes its first data byte as the new register pointer. Every later byte in that transaction is stored at the pointer, and the pointer then steps forward by one. A transaction addressed for reading returns the byte at the pointer and each byte after it. The pointer steps after every byte, so one long access runs through neighbouring registers in order.

The window holds several kinds of register. There is a version byte, two bytes mirrored from status inputs, a latched event-flag byte that empties when it is read, a watchdog reload byte whose zero value turns the watchdog off, a saturating LED level, a set of general scratch bytes, and a pattern buffer that can only be written. Locations without a register read as zero. The whole upper half of the window reads as 0xFF. The system clock oversamples both bus lines, and the target drives SDA through a single pull-low output.

Top module: `i2cRegBank`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x25). Address bit 0 set means read and clear means write. Any other address gets no acknowledge and leaves every register and the pointer unchanged until the next START.
- R2: In a write transaction the target acknowledges every data byte. The first data byte after the address loads the pointer and is not stored.
- R3: Each later write byte lands at the pointer, and the pointer then increments. The pointer also increments after each byte loaded for a read. It wraps from 0xFF to 0x00.
- R4: A read transaction returns the byte at the pointer and continues through the following addresses. The pointer survives STOP and repeated START, so a write that only sets the pointer, followed by a read, fetches from that location.
- R5: When the controller answers a read byte with NACK, the target releases SDA and stays off the bus until the next START. After a STOP, SDA is released.
- R6: Addresses 0x80 to 0xFF read as 0xFF, and writes to them are ignored.
- R7: Addresses 0x10 to 0x1F form a write-only pattern buffer. A write changes only the bytes it covers, and the buffer always reads back 0x00. Entry i is visible at the patRdData port when patRdIdx equals i.
- R8: Address 0x03 holds event flags in bit positions 0 to 4, one per eventPulse bit. A flag is set while its input is high and cleared when the byte is loaded for a read. An input that is high in the clearing cycle stays set. The byte reads 0x00 when nothing is pending.
- R9: Address 0x04 is a read/write watchdog reload value. It appears on wdogPeriod, and wdogEnable is high exactly when the value is non-zero.
- R10: Address 0x05 is a read/write LED level. Written values above 0x0F are stored as 0x0F. The level appears on ledLevel, and a read returns it zero-extended.
- R11: Address 0x00 reads VERSION (default 0xA3). Addresses 0x01 and 0x02 read statusIn[7:0] and statusIn[15:8]. Writes to these three addresses are ignored.
- R12: Addresses 0x08 to 0x0F are read/write scratch bytes. The unused addresses 0x06, 0x07 and 0x20 to 0x7F read 0x00 and ignore writes.
- R13: After reset, SDA is released, the pointer is 0x00, and all writable registers and event flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | High pulls SDA low; low releases it |
| statusIn | input | 16 | Status inputs shown at 0x01 and 0x02 |
| eventPulse | input | EVT_W (5) | Event inputs that set the flags at 0x03 |
| patRdIdx | input | log2(PAT_DEPTH) (4) | Selects the pattern buffer entry to expose |
| patRdData | output | 8 | Pattern buffer entry chosen by patRdIdx |
| wdogPeriod | output | 8 | Current watchdog reload value |
| wdogEnable | output | 1 | High while the reload value is non-zero |
| ledLevel | output | 4 | Current saturated LED level |

## Verification
The bench builds the block with its default parameters: DEV_ADDR 0x25, eight scratch bytes and a sixteen-entry pattern buffer. With these values the scratch bank ends at 0x0F and the pattern buffer ends at 0x1F, so a single burst can cross both boundaries and also the step from 0x7F to 0x80. A thirteen-byte write that starts at 0xFC wraps the pointer and walks over the read-only, event, watchdog and LED bytes before it reaches the first scratch byte. An event input held high across the clearing load shows that a flag is kept when it arrives during the read.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef struct packed {
    logic       ptrLoad;
    logic       wrStrobe;
    logic       rdLoad;
    logic [7:0] wrData;
  } busStrobeT;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR_BYTE,
    S_WR_ACK,
    S_RD_BIT,
    S_RD_ACK
  } ctrlStateT;

  localparam logic [7:0] ADDR_VER     = 8'h00;
  localparam logic [7:0] ADDR_STAT_LO = 8'h01;
  localparam logic [7:0] ADDR_STAT_HI = 8'h02;
  localparam logic [7:0] ADDR_EVT     = 8'h03;
  localparam logic [7:0] ADDR_WDOG    = 8'h04;
  localparam logic [7:0] ADDR_LED     = 8'h05;
  localparam logic [7:0] LED_MAX      = 8'h0F;

endpackage

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output busStrobeT  strobe,
  output logic       sdaDriveLow
);

  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic       sclNow, sdaNow, sclRise, sclFall, startCond, stopCond;

  ctrlStateT  state;
  logic [2:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic       byteDone, rnw, firstByte, masterAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclD;
  assign sclFall   = ~sclNow & sclD;
  assign startCond = sclNow & sclD & sdaD & ~sdaNow;
  assign stopCond  = sclNow & sclD & ~sdaD & sdaNow;

  always_comb begin
    strobe          = '0;
    strobe.wrData   = shReg;
    strobe.ptrLoad  = sclFall && state == S_WR_BYTE && byteDone && firstByte;
    strobe.wrStrobe = sclFall && state == S_WR_BYTE && byteDone && !firstByte;
    strobe.rdLoad   = sclFall && ((state == S_ADDR_ACK && rnw) ||
                                  (state == S_RD_ACK && masterAck));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shReg     <= '0;
      txReg     <= '0;
      byteDone  <= 1'b0;
      rnw       <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else if (startCond) begin
      state    <= S_ADDR;
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else if (stopCond) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_WR_BYTE: begin
          if (sclRise) begin
            shReg  <= {shReg[6:0], sdaNow};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteDone <= 1'b1;
          end else if (sclFall && byteDone) begin
            byteDone <= 1'b0;
            if (state == S_WR_BYTE) begin
              firstByte <= 1'b0;
              state     <= S_WR_ACK;
            end else if (shReg[7:1] == DEV_ADDR) begin
              rnw   <= shReg[0];
              state <= S_ADDR_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ADDR_ACK: if (sclFall) begin
          bitCnt <= '0;
          if (rnw) begin
            txReg <= rdData;
            state <= S_RD_BIT;
          end else begin
            firstByte <= 1'b1;
            state     <= S_WR_BYTE;
          end
        end
        S_WR_ACK: if (sclFall) state <= S_WR_BYTE;
        S_RD_BIT: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            bitCnt <= '0;
            state  <= S_RD_ACK;
          end else begin
            txReg  <= {txReg[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
          end
        end
        S_RD_ACK: begin
          if (sclRise) masterAck <= ~sdaNow;
          else if (sclFall) begin
            if (masterAck) begin
              txReg <= rdData;
              state <= S_RD_BIT;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state == S_ADDR_ACK) || (state == S_WR_ACK) ||
                       (state == S_RD_BIT && !txReg[7]);

  // R2 and R4: a single bus edge never yields more than one strobe
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ptrLoad, strobe.wrStrobe, strobe.rdLoad}));

  // R5: the line is free right after a STOP
  assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> !sdaDriveLow);

  // R5: a NACK from the controller makes the target let go of SDA
  assert_nack_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_ACK && sclFall && !masterAck) |=> (!sdaDriveLow && state == S_IDLE));

  // R1: a foreign address is never acknowledged
  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && sclFall && byteDone && shReg[7:1] != DEV_ADDR)
      |=> (state == S_IDLE && !sdaDriveLow));

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter logic [7:0] VERSION     = 8'hA3,
  parameter int         NUM_SCRATCH = 8,
  parameter int         PAT_DEPTH   = 16,
  parameter int         EVT_W       = 5,
  localparam int        PAT_IDX_W   = $clog2(PAT_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobeT            strobe,
  input  logic [15:0]          statusIn,
  input  logic [EVT_W-1:0]     eventPulse,
  input  logic [PAT_IDX_W-1:0] patRdIdx,
  output logic [7:0]           rdData,
  output logic [7:0]           patRdData,
  output logic [7:0]           wdogPeriod,
  output logic                 wdogEnable,
  output logic [3:0]           ledLevel
);

  localparam int         SCRATCH_BASE = 8;
  localparam int         PAT_BASE     = SCRATCH_BASE + NUM_SCRATCH;
  localparam logic [7:0] SCR_B        = 8'(SCRATCH_BASE);
  localparam logic [7:0] PAT_B        = 8'(PAT_BASE);

  logic [7:0]       ptr;
  logic [7:0]       scratch [NUM_SCRATCH];
  logic [7:0]       patMem  [PAT_DEPTH];
  logic [EVT_W-1:0] evtReg;
  logic [7:0]       wdReg;
  logic [3:0]       ledReg;
  logic             evtClr;

  always_ff @(posedge clk) begin
    if (!rstN)                                 ptr <= '0;
    else if (strobe.ptrLoad)                   ptr <= strobe.wrData;
    else if (strobe.wrStrobe || strobe.rdLoad) ptr <= ptr + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdReg  <= '0;
      ledReg <= '0;
    end else if (strobe.wrStrobe) begin
      if (ptr == ADDR_WDOG) wdReg <= strobe.wrData;
      if (ptr == ADDR_LED)
        ledReg <= (strobe.wrData > LED_MAX) ? LED_MAX[3:0] : strobe.wrData[3:0];
    end
  end

  generate
    for (genvar i = 0; i < NUM_SCRATCH; i++) begin : gScratch
      always_ff @(posedge clk) begin
        if (!rstN) scratch[i] <= '0;
        else if (strobe.wrStrobe && ptr == SCR_B + 8'(i)) scratch[i] <= strobe.wrData;
      end
    end
    for (genvar i = 0; i < PAT_DEPTH; i++) begin : gPattern
      always_ff @(posedge clk) begin
        if (!rstN) patMem[i] <= '0;
        else if (strobe.wrStrobe && ptr == PAT_B + 8'(i)) patMem[i] <= strobe.wrData;
      end
    end
  endgenerate

  assign evtClr = strobe.rdLoad && ptr == ADDR_EVT;

  generate
    for (genvar b = 0; b < EVT_W; b++) begin : gEvent
      always_ff @(posedge clk) begin
        if (!rstN) evtReg[b] <= 1'b0;
        else       evtReg[b] <= eventPulse[b] | (evtReg[b] & ~evtClr);
      end
    end
  endgenerate

  always_comb begin
    rdData = 8'h00;
    if (ptr[7]) begin
      rdData = 8'hFF;
    end else begin
      case (ptr)
        ADDR_VER:     rdData = VERSION;
        ADDR_STAT_LO: rdData = statusIn[7:0];
        ADDR_STAT_HI: rdData = statusIn[15:8];
        ADDR_EVT:     rdData = 8'(evtReg);
        ADDR_WDOG:    rdData = wdReg;
        ADDR_LED:     rdData = {4'h0, ledReg};
        default: begin
          for (int i = 0; i < NUM_SCRATCH; i++)
            if (ptr == SCR_B + 8'(i)) rdData = scratch[i];
        end
      endcase
    end
  end

  assign patRdData  = patMem[patRdIdx];
  assign wdogPeriod = wdReg;
  assign wdogEnable = |wdReg;
  assign ledLevel   = ledReg;

  // R3: every stored or fetched byte moves the pointer on by exactly one
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe || strobe.rdLoad) |=> ptr == $past(ptr) + 8'd1);

  // R10: an oversized LED value lands as the ceiling
  assert_led_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && ptr == ADDR_LED && strobe.wrData > LED_MAX) |=> ledLevel == LED_MAX[3:0]);

  // R8: the clearing load keeps only the events that arrive in that cycle
  assert_evt_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    evtClr |=> evtReg == $past(eventPulse));

endmodule

// File: rtl/i2cRegBank.sv
module i2cRegBank
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h25,
  parameter logic [7:0] VERSION     = 8'hA3,
  parameter int         NUM_SCRATCH = 8,
  parameter int         PAT_DEPTH   = 16,
  parameter int         EVT_W       = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  output logic                         sdaDriveLow,
  input  logic [15:0]                  statusIn,
  input  logic [EVT_W-1:0]             eventPulse,
  input  logic [$clog2(PAT_DEPTH)-1:0] patRdIdx,
  output logic [7:0]                   patRdData,
  output logic [7:0]                   wdogPeriod,
  output logic                         wdogEnable,
  output logic [3:0]                   ledLevel
);

  busStrobeT  strobe;
  logic [7:0] rdData;

  i2cSlaveCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .rdData      (rdData),
    .strobe      (strobe),
    .sdaDriveLow (sdaDriveLow)
  );

  i2cRegData #(
    .VERSION     (VERSION),
    .NUM_SCRATCH (NUM_SCRATCH),
    .PAT_DEPTH   (PAT_DEPTH),
    .EVT_W       (EVT_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statusIn   (statusIn),
    .eventPulse (eventPulse),
    .patRdIdx   (patRdIdx),
    .rdData     (rdData),
    .patRdData  (patRdData),
    .wdogPeriod (wdogPeriod),
    .wdogEnable (wdogEnable),
    .ledLevel   (ledLevel)
  );

endmodule

// File: tb/i2cRegBank_bench.sv
module i2cRegBank_bench;

  localparam logic [6:0]  DEV = 7'h25;
  localparam logic [7:0]  VER = 8'hA3;
  localparam logic [15:0] STATUS_VAL = 16'hC35A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       mLow = 1'b0;
  logic [4:0] eventPulse = '0;
  logic [3:0] patRdIdx = '0;
  logic       sdaDriveLow, wdogEnable, sdaLine;
  logic [7:0] patRdData, wdogPeriod;
  logic [3:0] ledLevel;

  int checks = 0;
  int errors = 0;
  bit syncOk = 1'b0;

  // behavioural model of the register window
  logic [7:0] mScr [8];
  logic [7:0] mPat [16];
  logic [7:0] mWd, mLed, mEvt;
  int         mPtr;
  logic [7:0] wq [$];

  always #4 clk = ~clk;

  assign sdaLine = ~(mLow | sdaDriveLow);

  i2cRegBank u_i2cRegBank (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclLine),
    .sdaIn       (sdaLine),
    .sdaDriveLow (sdaDriveLow),
    .statusIn    (STATUS_VAL),
    .eventPulse  (eventPulse),
    .patRdIdx    (patRdIdx),
    .patRdData   (patRdData),
    .wdogPeriod  (wdogPeriod),
    .wdogEnable  (wdogEnable),
    .ledLevel    (ledLevel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(input int a);
    if (a >= 128)            return 8'hFF;
    if (a == 0)              return VER;
    if (a == 1)              return STATUS_VAL[7:0];
    if (a == 2)              return STATUS_VAL[15:8];
    if (a == 3)              return mEvt;
    if (a == 4)              return mWd;
    if (a == 5)              return mLed;
    if (a >= 8 && a < 16)    return mScr[a-8];
    return 8'h00;
  endfunction

  task automatic mWrite(input int a, input logic [7:0] d);
    if (a == 4) mWd = d;
    else if (a == 5) mLed = (d > 8'h0F) ? 8'h0F : d;
    else if (a >= 8 && a < 16) mScr[a-8] = d;
    else if (a >= 16 && a < 32) mPat[a-16] = d;
  endtask

  // outputs compared against the model on every clock while the bus is quiet
  always @(negedge clk) begin
    if (syncOk && rstN) begin
      check(wdogEnable == (mWd != 0), "R9", "wdogEnable", wdogEnable, mWd != 0);
      check(wdogPeriod == mWd, "R9", "wdogPeriod", wdogPeriod, mWd);
      check(ledLevel == mLed[3:0], "R10", "ledLevel", ledLevel, mLed);
    end
  end

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2cStart();
    mLow = 1'b0; q(); sclLine = 1'b1; q(); mLow = 1'b1; q(); sclLine = 1'b0; q();
  endtask

  task automatic i2cStop();
    mLow = 1'b1; q(); sclLine = 1'b1; q(); mLow = 1'b0; q(); q();
  endtask

  task automatic writeBit(input bit v);
    mLow = !v; q(); sclLine = 1'b1; q(); q(); sclLine = 1'b0; q();
  endtask

  task automatic readBit(output bit v);
    mLow = 1'b0; q(); sclLine = 1'b1; q(); v = sdaLine; q(); sclLine = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    readBit(x);
    ack = !x;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      readBit(x);
      b[i] = x;
    end
    writeBit(!ack);
  endtask

  task automatic wrBody(input logic [7:0] p);
    bit ack;
    sendByte({DEV, 1'b0}, ack);
    check(ack, "R1", "write address ack", ack, 1);
    sendByte(p, ack);
    check(ack, "R2", "pointer byte ack", ack, 1);
    mPtr = p;
    foreach (wq[i]) begin
      sendByte(wq[i], ack);
      check(ack, "R2", "data byte ack", ack, 1);
      mWrite(mPtr, wq[i]);
      mPtr = (mPtr + 1) % 256;
    end
    wq.delete();
  endtask

  task automatic rdBody(input int n, input string req);
    bit ack;
    logic [7:0] v, exp;
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R1", "read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i != n - 1);
      exp = mRead(mPtr);
      if (mPtr == 3) mEvt = 8'h00;
      check(v == exp, req, $sformatf("read at %0h", mPtr), v, exp);
      mPtr = (mPtr + 1) % 256;
    end
  endtask

  task automatic wrTxn(input logic [7:0] p);
    syncOk = 1'b0; i2cStart(); wrBody(p); i2cStop(); syncOk = 1'b1;
  endtask

  task automatic rdTxn(input int n, input string req);
    syncOk = 1'b0; i2cStart(); rdBody(n, req); i2cStop(); syncOk = 1'b1;
  endtask

  task automatic patCheck();
    for (int i = 0; i < 16; i++) begin
      patRdIdx = 4'(i);
      @(negedge clk);
      check(patRdData == mPat[i], "R7", $sformatf("pattern entry %0d", i), patRdData, mPat[i]);
    end
  endtask

  task automatic pulseEvt(input logic [4:0] m);
    eventPulse = m; @(negedge clk); eventPulse = '0; @(negedge clk);
    mEvt = mEvt | 8'(m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack, x;
    logic [7:0] v;
    foreach (mScr[i]) mScr[i] = '0;
    foreach (mPat[i]) mPat[i] = '0;
    mWd = '0; mLed = '0; mEvt = '0; mPtr = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R13: reset state seen at the ports
    check(sdaLine == 1'b1, "R13", "SDA released", sdaLine, 1);
    check(wdogEnable == 1'b0, "R13", "watchdog off", wdogEnable, 0);
    check(ledLevel == 4'h0, "R13", "LED level", ledLevel, 0);
    patCheck();
    syncOk = 1'b1;
    rdTxn(1, "R13");

    // R1: foreign address is not acknowledged and writes nothing
    syncOk = 1'b0;
    i2cStart();
    sendByte({DEV ^ 7'h01, 1'b0}, ack);
    check(!ack, "R1", "foreign address nack", ack, 0);
    sendByte(8'h08, ack);
    sendByte(8'hEE, ack);
    check(!ack, "R1", "foreign data ignored", ack, 0);
    i2cStop();
    syncOk = 1'b1;
    wrTxn(8'h08);
    rdTxn(1, "R1");

    // R2, R3, R12: burst write into scratch and read back
    wq = '{8'h11, 8'h22, 8'h33};
    wrTxn(8'h08);
    wrTxn(8'h08);
    rdTxn(3, "R12");

    // R9, R10: watchdog value then oversized LED value in one burst
    wq = '{8'h40, 8'h25};
    wrTxn(8'h04);
    wrTxn(8'h05);
    rdTxn(1, "R10");
    wq = '{8'h00, 8'h09};
    wrTxn(8'h04);
    wrTxn(8'h04);
    rdTxn(2, "R9");

    // R11: read-only bytes keep their value after writes
    wq = '{8'h55, 8'h66, 8'h77};
    wrTxn(8'h00);
    wrTxn(8'h00);
    rdTxn(8, "R11");

    // R8: flags latch, read out, then read empty
    pulseEvt(5'b01001);
    wrTxn(8'h03);
    rdTxn(1, "R8");
    wrTxn(8'h03);
    rdTxn(1, "R8");

    // R8: event held high across the clearing load is kept (repeated start, R4)
    pulseEvt(5'b00001);
    syncOk = 1'b0;
    i2cStart();
    wrBody(8'h03);
    i2cStart();
    eventPulse = 5'b10000;
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R4", "repeated start read ack", ack, 1);
    eventPulse = '0;
    recvByte(v, 1'b0);
    check(v == 8'h11, "R8", "read with concurrent event", v, 8'h11);
    i2cStop();
    syncOk = 1'b1;
    mEvt = 8'h10;
    wrTxn(8'h03);
    rdTxn(1, "R8");
    wrTxn(8'h03);
    rdTxn(1, "R8");

    // R7: partial writes to the pattern buffer, reads give zero
    wq = '{8'hAA, 8'hBB};
    wrTxn(8'h12);
    patCheck();
    wq = '{8'hCC};
    wrTxn(8'h13);
    patCheck();
    wrTxn(8'h0E);
    rdTxn(8, "R7");

    // R6, R12: reserved bytes and the upper half
    wq = '{8'h77};
    wrTxn(8'h90);
    wq = '{8'h5C, 8'h6D};
    wrTxn(8'h06);
    wrTxn(8'h7E);
    rdTxn(4, "R6");
    wrTxn(8'h06);
    rdTxn(2, "R12");

    // R3: pointer wraps on read and on a long write
    wrTxn(8'hFF);
    rdTxn(2, "R3");
    for (int i = 0; i < 13; i++) wq.push_back(8'(8'h60 + i));
    wrTxn(8'hFC);
    wrTxn(8'h00);
    rdTxn(9, "R3");

    // R5: NACK releases SDA; the next read continues from the advanced pointer
    wrTxn(8'h08);
    syncOk = 1'b0;
    i2cStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R5", "read address ack", ack, 1);
    recvByte(v, 1'b0);
    check(v == mRead(mPtr), "R5", "byte before nack", v, mRead(mPtr));
    mPtr = (mPtr + 1) % 256;
    for (int i = 0; i < 9; i++) begin
      readBit(x);
      check(x == 1'b1, "R5", "SDA released after nack", x, 1);
    end
    i2cStop();
    check(sdaLine == 1'b1, "R5", "SDA after stop", sdaLine, 1);
    syncOk = 1'b1;
    rdTxn(2, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule